// File: doc/BRIEF.md
# Timer-Triggered Pattern Output Controller

This block drives a parallel output word split into nibble-wide groups. Software loads a staged data word, a per-bit transfer mask and a per-group trigger selection through a small register port. Each group watches the single-cycle compare-match strobe of the timer channel it has chosen. When that strobe arrives, the group's output latch takes the staged bits, but only where the mask allows it. Masked bits and groups that do not fire keep their current value.

The typical use is stepper-motor or multiplexed-display patterns. Software stages the next pattern ahead of time, and the timer edge publishes it with no software latency. Because each group chooses its own channel, up to four unrelated patterns can run at independent rates from a single output word.

A separate low-power clear input returns the staged data, the mask and the output latch to zero, but leaves the trigger selection unchanged. A full reset restores every register.

Top module: `pattern_out_ctrl`

## Requirements
- R1: After `rst`, `pat_out` is 0, the staged data and the transfer mask read back as 0, and the trigger selection reads back as 0x00FF. In the reset value every group uses channel 3.
- R2: Group g owns output bits [4g+3:4g] and selection field bits [2g+1:2g]. A strobe that group g selects changes no bit outside group g.
- R3: A selection field value k (0 to 3) makes that group trigger on `cmp_match[k]`, and on no other channel.
- R4: On a rising clock edge where a group's selected strobe is high, each bit of that group whose mask bit is 1 takes the corresponding staged data bit. `pat_out` shows the result after that edge.
- R5: A bit whose mask bit is 0 keeps its latch value, even when its group fires.
- R6: A group whose selected strobe is low holds its value. Several groups that fire on the same edge each update independently.
- R7: `sleep_clr` clears the staged data, the mask and the output latch on the next edge. It leaves the trigger selection unchanged.
- R8: Register reads return data one cycle after `reg_rd`. The address encoding is 0 = staged data, 1 = mask, 2 = selection (in bits 7:0, upper bits read 0), 3 = output latch (read only, writes are ignored).
- R9: When a register write and a trigger land on the same edge, the transfer uses the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_clr | input | 1 | Low-power clear; keeps the trigger selection |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after `reg_rd` |
| cmp_match | input | 4 | Single-cycle compare-match strobes, one per timer channel |
| pat_out | output | 16 | Registered output latch |

## Verification
The bench uses the default configuration of four groups of four bits and four channels, which is small enough to sweep completely. It walks all 256 trigger-selection words, and for each word it applies all 16 combinations of strobes. Every pairing of group, selection value and channel is therefore exercised, including every multi-group firing. Staged-data and mask values change between selection words, so masked and unmasked bits both see transfers.

// File: rtl/tpo_pkg.sv
package tpo_pkg;
  typedef enum logic [1:0] {
    ADDR_NEXT  = 2'd0,
    ADDR_MASK  = 2'd1,
    ADDR_SEL   = 2'd2,
    ADDR_LATCH = 2'd3
  } tpo_addr_e;
endpackage

// File: rtl/tpo_regs.sv
module tpo_regs
  import tpo_pkg::*;
#(
  parameter int DW  = 16,
  parameter int TSW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sleep_clr,
  input  logic           wr,
  input  logic [1:0]     addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  nd_q,
  output logic [DW-1:0]  en_q,
  output logic [TSW-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (rst || sleep_clr) begin
      nd_q <= '0;
      en_q <= '0;
    end else if (wr) begin
      if (addr == ADDR_NEXT) nd_q <= wdata;
      if (addr == ADDR_MASK) en_q <= wdata;
    end
  end

  // Selection survives the low-power clear; only a full reset restores it.
  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= '1;
    else if (wr && addr == ADDR_SEL)
      sel_q <= wdata[TSW-1:0];
  end
endmodule

// File: rtl/tpo_group.sv
module tpo_group #(
  parameter int GW       = 4,
  parameter int CHANNELS = 4,
  parameter int SW       = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sleep_clr,
  input  logic [CHANNELS-1:0] cmp_match,
  input  logic [SW-1:0]       sel,
  input  logic [GW-1:0]       nd,
  input  logic [GW-1:0]       en,
  output logic [GW-1:0]       q
);
  logic fire;

  always_comb begin
    fire = 1'b0;
    for (int c = 0; c < CHANNELS; c++)
      if (sel == SW'(c)) fire = cmp_match[c];
  end

  always_ff @(posedge clk) begin
    if (rst || sleep_clr)
      q <= '0;
    else if (fire)
      q <= (nd & en) | (q & ~en);
  end
endmodule

// File: rtl/pattern_out_ctrl.sv
module pattern_out_ctrl
  import tpo_pkg::*;
#(
  parameter int GROUPS   = 4,
  parameter int GW       = 4,
  parameter int CHANNELS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sleep_clr,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic [1:0]                     reg_addr,
  input  logic [GROUPS*GW-1:0]           reg_wdata,
  output logic [GROUPS*GW-1:0]           reg_rdata,
  input  logic [CHANNELS-1:0]            cmp_match,
  output logic [GROUPS*GW-1:0]           pat_out
);
  localparam int DW  = GROUPS * GW;
  localparam int SW  = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
  localparam int TSW = GROUPS * SW;

  logic [DW-1:0]  nd_q;
  logic [DW-1:0]  en_q;
  logic [TSW-1:0] sel_q;

  tpo_regs #(.DW(DW), .TSW(TSW)) u_regs (
    .clk(clk), .rst(rst), .sleep_clr(sleep_clr),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .nd_q(nd_q), .en_q(en_q), .sel_q(sel_q)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    tpo_group #(.GW(GW), .CHANNELS(CHANNELS), .SW(SW)) u_grp (
      .clk(clk), .rst(rst), .sleep_clr(sleep_clr),
      .cmp_match(cmp_match),
      .sel(sel_q[g*SW +: SW]),
      .nd(nd_q[g*GW +: GW]),
      .en(en_q[g*GW +: GW]),
      .q(pat_out[g*GW +: GW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        ADDR_NEXT: reg_rdata <= nd_q;
        ADDR_MASK: reg_rdata <= en_q;
        ADDR_SEL:  reg_rdata <= DW'(sel_q);
        default:   reg_rdata <= pat_out;
      endcase
    end
  end
endmodule

// File: rtl/tpo_checker.sv
module tpo_checker
  import tpo_pkg::*;
#(
  parameter int DW  = 16,
  parameter int TSW = 8,
  parameter int CH  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           sleep_clr,
  input logic           reg_wr,
  input logic [1:0]     reg_addr,
  input logic [CH-1:0]  cmp_match,
  input logic [DW-1:0]  pat_out,
  input logic [DW-1:0]  en_q,
  input logic [TSW-1:0] sel_q
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pat_out == '0 && en_q == '0 && sel_q == '1));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (cmp_match == '0 && !sleep_clr) |=> $stable(pat_out));

  a_r5_masked_hold: assert property (@(posedge clk) disable iff (rst || sleep_clr)
    1'b1 |=> (((pat_out ^ $past(pat_out)) & ~$past(en_q)) == '0));

  a_r7_sleep_clear: assert property (@(posedge clk) disable iff (rst)
    sleep_clr |=> (pat_out == '0 && en_q == '0));

  a_r7_sel_kept: assert property (@(posedge clk) disable iff (rst)
    (sleep_clr && !(reg_wr && reg_addr == ADDR_SEL)) |=> $stable(sel_q));
endmodule

bind pattern_out_ctrl tpo_checker #(.DW(DW), .TSW(TSW), .CH(CHANNELS)) u_chk (
  .clk(clk), .rst(rst), .sleep_clr(sleep_clr), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .cmp_match(cmp_match), .pat_out(pat_out),
  .en_q(en_q), .sel_q(sel_q)
);

// File: tb/pattern_out_ctrl_test.sv
module pattern_out_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleep_clr = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [3:0]  cmp_match = 4'd0;
  logic [15:0] pat_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_nd = 0, m_en = 0, m_out = 0;
  logic [7:0]  m_sel = 8'hFF;
  logic [15:0] rv;

  always #10 clk = ~clk;

  pattern_out_ctrl uut (
    .clk(clk), .rst(rst), .sleep_clr(sleep_clr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmp_match(cmp_match), .pat_out(pat_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] apply(input logic [15:0] o, input logic [3:0] m);
    logic [15:0] r = o;
    for (int g = 0; g < 4; g++)
      if (m[m_sel[2*g +: 2]])
        for (int b = 4*g; b < 4*g+4; b++)
          if (m_en[b]) r[b] = m_nd[b];
    return r;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0) m_nd = d;
    if (a == 2'd1) m_en = d;
    if (a == 2'd2) m_sel = d[7:0];
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic pulse(input logic [3:0] m, input string req);
    cmp_match = m;
    @(negedge clk);
    cmp_match = 4'd0;
    m_out = apply(m_out, m);
    check(req, pat_out, m_out);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", pat_out, 16'h0);
    rd(2'd0, rv); check("R1", rv, 16'h0);
    rd(2'd1, rv); check("R1", rv, 16'h0);
    rd(2'd2, rv); check("R1", rv, 16'h00FF);
    // R4: transfers are blocked while the mask is zero
    wr(2'd0, 16'hFFFF);
    pulse(4'b1000, "R4");
    // R5: only masked-in bits move
    wr(2'd1, 16'h00F0); wr(2'd2, 16'h0000);
    pulse(4'b0001, "R5");
    check("R5", pat_out, 16'h00F0);
    // R2: group 2 on channel 1, the rest on channel 3
    wr(2'd1, 16'hFFFF); wr(2'd0, 16'hABCD); wr(2'd2, 16'h00DF);
    pulse(4'b0010, "R2");
    check("R2", pat_out, 16'h0BF0);
    // R6: no strobe holds, then several groups fire together
    pulse(4'b0000, "R6");
    pulse(4'b1010, "R6");
    // R9: the write and the trigger share an edge; the old staged data wins
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h1234; cmp_match = 4'b1000;
    @(negedge clk);
    reg_wr = 1'b0; cmp_match = 4'd0;
    m_out = apply(m_out, 4'b1000); m_nd = 16'h1234;
    check("R9", pat_out, m_out);
    // R8: readback, read-only latch, upper selection bits
    rd(2'd3, rv); check("R8", rv, m_out);
    wr(2'd3, 16'h5555);
    check("R8", pat_out, m_out);
    rd(2'd3, rv); check("R8", rv, m_out);
    wr(2'd2, 16'hFF1B);
    rd(2'd2, rv); check("R8", rv, 16'h001B);
    rd(2'd0, rv); check("R8", rv, 16'h1234);
    // R3 sweep: every selection word against every strobe combination
    for (int s = 0; s < 256; s++) begin
      wr(2'd2, 16'(s));
      wr(2'd0, 16'(s * 16'h9E37 + 16'h3C5A));
      wr(2'd1, 16'(~(s * 16'h0101)) | 16'h8421);
      for (int m = 0; m < 16; m++) pulse(4'(m), "R3");
    end
    // R7: the low-power clear keeps the selection
    wr(2'd2, 16'h001B);
    sleep_clr = 1'b1;
    @(negedge clk);
    sleep_clr = 1'b0;
    m_out = 0; m_nd = 0; m_en = 0;
    check("R7", pat_out, 16'h0);
    rd(2'd0, rv); check("R7", rv, 16'h0);
    rd(2'd1, rv); check("R7", rv, 16'h0);
    rd(2'd2, rv); check("R7", rv, 16'h001B);
    // R1: reset restores the selection
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    rd(2'd2, rv); check("R1", rv, 16'h00FF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule